// File: doc/BRIEF.md
# QDR Write Burst Serializer

This block turns one wide write transfer into a double-data-rate burst for a 36-bit quad-data-rate SRAM write port. The user side offers a 288-bit data word and a 32-bit strobe word under a valid/ready handshake. Once a transfer is taken, the block spends four clock cycles presenting it to the memory side. On each clock it gives one 36-bit value for the rising edge and one for the falling edge. For each of those half-cycle beats it also gives four active-low byte-write selects, one per 9-bit lane.

The strobe bits are not consumed in their natural order. For each lane and each beat the block picks the strobe bit from an interleaved index. Strobe bit 0 guards data bits 0 to 8, but strobe bit 1 guards data bits 144 to 152. The physical DDR output cells sit downstream and take the rising and falling values directly. Address and control sequencing are handled elsewhere.

Top module: `qdr_wr_serializer`

## Requirements
- R1: After reset the block is idle: `in_ready` is 1, `out_active` is 0, both data outputs are all zero and all eight select outputs are 1.
- R2: A transfer is taken on a rising clock edge where `in_valid` and `in_ready` are both 1. `out_active` is 1 for exactly the next 4 clock cycles.
- R3: `in_ready` is 0 in every cycle where `out_active` is 1, and it is 1 again in the cycle after the last beat. While `in_ready` is 0, the values on `in_valid`, `in_data` and `in_strb` do not change the burst in progress.
- R4: Beat b (b = 0..7) carries bits 36b+35..36b of the data word. In burst cycle k (k = 0..3) the rising output carries beat 2k and the falling output carries beat 2k+1.
- R5: Within a beat, lane L (L = 0..3) is data bits 9L+8..9L of the 36-bit output, and select bit L belongs to that lane.
- R6: The select for lane L in beat b is the inverse of strobe bit 2L + (1 if b >= 4, else 0) + 8*(b mod 4). A strobe bit of 1 means write, so the select output is 0.
- R7: In every cycle where `out_active` is 0, the data outputs are zero and all select outputs are 1.
- R8: If `in_valid` is still 1 when `in_ready` returns, a new transfer is taken in that cycle. Its burst starts on the next cycle, which leaves exactly one idle cycle between bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising-edge registers |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Transfer offered |
| in_ready | output | 1 | Block can take a transfer |
| in_data | input | 288 | Write data word, 8 beats of 36 bits |
| in_strb | input | 32 | Write strobe word, 1 = write |
| out_active | output | 1 | Burst beat in progress this cycle |
| out_d_rise | output | 36 | Data for the rising-edge beat |
| out_d_fall | output | 36 | Data for the falling-edge beat |
| out_bws_rise_n | output | 4 | Active-low lane selects, rising beat |
| out_bws_fall_n | output | 4 | Active-low lane selects, falling beat |

## Verification
The bench uses random data words with all-zero and all-one strobes. These show whether data ordering is right on its own and whether selects track the strobe word as a whole. It also sends single-bit strobes at bits 1, 8 and 31. Each of these lights exactly one lane in one beat, so a plain byte-per-lane slice or a swapped half shows up as a select in the wrong place. Random strobes with distinct data words, sent back to back while `in_valid` is held high, show whether a waiting transfer leaks into a running burst and whether the one-cycle gap between bursts holds.

// File: rtl/qws_pkg.sv
package qws_pkg;

    parameter int QWS_LANE_W = 9;
    parameter int QWS_LANES  = 4;
    parameter int QWS_BEATS  = 8;

    // Strobe bit used by a lane in a given beat: lanes pair up on even/odd
    // bits, the second half of the burst takes the odd bit, and each beat
    // inside a half steps by one full lane-pair group.
    function automatic int strobe_index(input int lane, input int beat,
                                        input int lanes, input int beats);
        int half_len;
        half_len = beats / 2;
        return 2 * lane + ((beat >= half_len) ? 1 : 0) + 2 * lanes * (beat % half_len);
    endfunction

endpackage

// File: rtl/qws_ctrl.sv
module qws_ctrl #(
    parameter int CYCLES = 4,
    parameter int CYC_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             ready,
    output logic             load,
    output logic             active,
    output logic [CYC_W-1:0] cyc
);

    typedef struct packed {
        logic             busy;
        logic [CYC_W-1:0] cyc;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        if (!st_q.busy) begin
            if (in_valid) begin
                load      = 1'b1;
                st_d.busy = 1'b1;
                st_d.cyc  = '0;
            end
        end else if (st_q.cyc == CYC_W'(CYCLES - 1)) begin
            st_d.busy = 1'b0;
            st_d.cyc  = '0;
        end else begin
            st_d.cyc = st_q.cyc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready  = ~st_q.busy;
    assign active = st_q.busy;
    assign cyc    = st_q.cyc;

endmodule

// File: rtl/qws_beat_mux.sv
module qws_beat_mux #(
    parameter int BUS_W = 36,
    parameter int BEATS = 8,
    parameter int CYC_W = 2,
    localparam int DATA_W = BUS_W * BEATS
) (
    input  logic [DATA_W-1:0] data,
    input  logic [CYC_W-1:0]  cyc,
    input  logic              active,
    output logic [BUS_W-1:0]  d_rise,
    output logic [BUS_W-1:0]  d_fall
);

    logic [BUS_W-1:0] beat_w [BEATS];

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        assign beat_w[b] = data[b*BUS_W +: BUS_W];
    end

    always_comb begin
        d_rise = '0;
        d_fall = '0;
        if (active) begin
            d_rise = beat_w[{cyc, 1'b0}];
            d_fall = beat_w[{cyc, 1'b1}];
        end
    end

endmodule

// File: rtl/qws_lane_sel.sv
module qws_lane_sel
    import qws_pkg::*;
#(
    parameter int LANES = 4,
    parameter int BEATS = 8,
    parameter int CYC_W = 2,
    localparam int STRB_W = LANES * BEATS,
    localparam int CYCLES = BEATS / 2
) (
    input  logic [STRB_W-1:0] strb,
    input  logic [CYC_W-1:0]  cyc,
    input  logic              active,
    output logic [LANES-1:0]  bws_rise_n,
    output logic [LANES-1:0]  bws_fall_n
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [CYCLES-1:0] pick_r, pick_f;

        for (genvar k = 0; k < CYCLES; k++) begin : g_cyc
            localparam int IDX_R = strobe_index(l, 2 * k,     LANES, BEATS);
            localparam int IDX_F = strobe_index(l, 2 * k + 1, LANES, BEATS);
            assign pick_r[k] = strb[IDX_R];
            assign pick_f[k] = strb[IDX_F];
        end

        always_comb begin
            bws_rise_n[l] = 1'b1;
            bws_fall_n[l] = 1'b1;
            if (active) begin
                bws_rise_n[l] = ~pick_r[cyc];
                bws_fall_n[l] = ~pick_f[cyc];
            end
        end
    end

endmodule

// File: rtl/qdr_wr_serializer.sv
module qdr_wr_serializer
    import qws_pkg::*;
#(
    parameter int LANE_W = QWS_LANE_W,
    parameter int LANES  = QWS_LANES,
    parameter int BEATS  = QWS_BEATS,
    localparam int BUS_W  = LANE_W * LANES,
    localparam int DATA_W = BUS_W * BEATS,
    localparam int STRB_W = LANES * BEATS,
    localparam int CYCLES = BEATS / 2,
    localparam int CYC_W  = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [STRB_W-1:0] in_strb,
    output logic              out_active,
    output logic [BUS_W-1:0]  out_d_rise,
    output logic [BUS_W-1:0]  out_d_fall,
    output logic [LANES-1:0]  out_bws_rise_n,
    output logic [LANES-1:0]  out_bws_fall_n
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
    } payload_t;

    payload_t pl_d, pl_q;
    logic             load;
    logic [CYC_W-1:0] cyc;

    qws_ctrl #(
        .CYCLES (CYCLES),
        .CYC_W  (CYC_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .ready    (in_ready),
        .load     (load),
        .active   (out_active),
        .cyc      (cyc)
    );

    always_comb begin
        pl_d = pl_q;
        if (load) begin
            pl_d.data = in_data;
            pl_d.strb = in_strb;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pl_q <= '0;
        end else begin
            pl_q <= pl_d;
        end
    end

    qws_beat_mux #(
        .BUS_W (BUS_W),
        .BEATS (BEATS),
        .CYC_W (CYC_W)
    ) u_mux (
        .data   (pl_q.data),
        .cyc    (cyc),
        .active (out_active),
        .d_rise (out_d_rise),
        .d_fall (out_d_fall)
    );

    qws_lane_sel #(
        .LANES (LANES),
        .BEATS (BEATS),
        .CYC_W (CYC_W)
    ) u_sel (
        .strb       (pl_q.strb),
        .cyc        (cyc),
        .active     (out_active),
        .bws_rise_n (out_bws_rise_n),
        .bws_fall_n (out_bws_fall_n)
    );

endmodule

// File: rtl/qws_checker.sv
module qws_checker #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    parameter int BEATS  = 8,
    localparam int BUS_W  = LANE_W * LANES,
    localparam int DATA_W = BUS_W * BEATS,
    localparam int STRB_W = LANES * BEATS,
    localparam int CYCLES = BEATS / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic [STRB_W-1:0] in_strb,
    input logic              out_active,
    input logic [BUS_W-1:0]  out_d_rise,
    input logic [BUS_W-1:0]  out_d_fall,
    input logic [LANES-1:0]  out_bws_rise_n,
    input logic [LANES-1:0]  out_bws_fall_n
);

    logic [7:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (out_active) begin
            run_cnt <= run_cnt + 8'd1;
        end else begin
            run_cnt <= '0;
        end
    end

    a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_active);

    a_r2_burst_ends: assert property (@(posedge clk) disable iff (!rst_n)
        out_active && run_cnt == 8'(CYCLES - 1) |=> !out_active);

    a_r2_burst_holds: assert property (@(posedge clk) disable iff (!rst_n)
        out_active && run_cnt < 8'(CYCLES - 1) |=> out_active);

    a_r3_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        out_active |-> !in_ready);

    a_r3_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_active) |-> in_ready);

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_active |-> (out_d_rise == '0 && out_d_fall == '0 &&
                         &out_bws_rise_n && &out_bws_fall_n));

    a_r4_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_active) |-> out_d_rise == $past(in_data[BUS_W-1:0]));

    a_r6_first_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_active) |-> out_bws_rise_n[0] == !$past(in_strb[0]));

endmodule

bind qdr_wr_serializer qws_checker #(
    .LANE_W (LANE_W),
    .LANES  (LANES),
    .BEATS  (BEATS)
) u_qws_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .in_data        (in_data),
    .in_strb        (in_strb),
    .out_active     (out_active),
    .out_d_rise     (out_d_rise),
    .out_d_fall     (out_d_fall),
    .out_bws_rise_n (out_bws_rise_n),
    .out_bws_fall_n (out_bws_fall_n)
);

// File: tb/tb_qdr_wr_serializer.sv
module tb_qdr_wr_serializer;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [287:0] in_data = '0;
    logic [31:0]  in_strb = '0;
    logic         out_active;
    logic [35:0]  out_d_rise, out_d_fall;
    logic [3:0]   out_bws_rise_n, out_bws_fall_n;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    qdr_wr_serializer dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_data        (in_data),
        .in_strb        (in_strb),
        .out_active     (out_active),
        .out_d_rise     (out_d_rise),
        .out_d_fall     (out_d_fall),
        .out_bws_rise_n (out_bws_rise_n),
        .out_bws_fall_n (out_bws_fall_n)
    );

    // Behavioural reference: a transfer in flight plus a beat cycle counter.
    bit         m_busy = 1'b0;
    int         m_cyc = 0;
    bit [287:0] m_data = '0;
    bit [31:0]  m_strb = '0;
    bit         m_check = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0;
            m_cyc  = 0;
        end else if (!m_busy) begin
            if (in_valid) begin
                m_busy = 1'b1;
                m_cyc  = 0;
                m_data = in_data;
                m_strb = in_strb;
            end
        end else if (m_cyc == 3) begin
            m_busy = 1'b0;
        end else begin
            m_cyc = m_cyc + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int sidx(int lane, int beat);
        int h;
        h = (beat >= 4) ? 1 : 0;
        return 2 * lane + h + 8 * (beat % 4);
    endfunction

    always @(negedge clk) begin
        if (rst_n && m_check) begin
            chk(out_active == m_busy, "R2", "out_active", 64'(out_active), 64'(m_busy));
            chk(in_ready == !m_busy, "R3", "in_ready", 64'(in_ready), 64'(!m_busy));
            if (!m_busy) begin
                chk(out_d_rise == '0 && out_d_fall == '0, "R7", "idle data",
                    64'({out_d_rise, out_d_fall}), 64'd0);
                chk(out_bws_rise_n == 4'hf && out_bws_fall_n == 4'hf, "R7", "idle selects",
                    64'({out_bws_rise_n, out_bws_fall_n}), 64'hff);
            end else begin
                for (int e = 0; e < 2; e++) begin
                    int b;
                    logic [35:0] dv;
                    logic [3:0]  sv;
                    b  = 2 * m_cyc + e;
                    dv = (e == 0) ? out_d_rise : out_d_fall;
                    sv = (e == 0) ? out_bws_rise_n : out_bws_fall_n;
                    for (int l = 0; l < 4; l++) begin
                        logic [8:0] exp_lane;
                        logic       exp_sel;
                        exp_lane = m_data[36 * b + 9 * l +: 9];
                        exp_sel  = ~m_strb[sidx(l, b)];
                        chk(dv[9 * l +: 9] == exp_lane, "R4 R5", "lane data",
                            64'(dv[9 * l +: 9]), 64'(exp_lane));
                        chk(sv[l] == exp_sel, "R6", "lane select",
                            64'(sv[l]), 64'(exp_sel));
                    end
                end
            end
        end
    end

    function automatic logic [287:0] rnd_data();
        logic [287:0] v;
        for (int i = 0; i < 9; i++) v[32 * i +: 32] = $urandom();
        return v;
    endfunction

    // Offer a transfer; returns at the negedge after it was taken.
    task automatic send(input logic [287:0] d, input logic [31:0] s, input bit keep);
        in_valid = 1'b1;
        in_data  = d;
        in_strb  = s;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        if (!keep) in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs under reset hold, then after release
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_active == 1'b0, "R1", "ready/active after reset",
            64'({in_ready, out_active}), 64'b10);
        chk(out_d_rise == '0 && out_d_fall == '0 && out_bws_rise_n == 4'hf &&
            out_bws_fall_n == 4'hf, "R1", "outputs after reset",
            64'({out_bws_rise_n, out_bws_fall_n}), 64'hff);
        m_check = 1'b1;

        send(rnd_data(), 32'h0, 1'b0);          // no lane written
        idle(6);
        send(rnd_data(), 32'hffff_ffff, 1'b0);  // every lane written
        idle(6);
        send(rnd_data(), 32'h0000_0002, 1'b0);  // R6: lane 0 in beat 4 only
        idle(6);
        send(rnd_data(), 32'h0000_0100, 1'b0);  // R6: lane 0 in beat 1 only
        idle(6);
        send(rnd_data(), 32'h8000_0000, 1'b0);  // R6: lane 3 in beat 7 only
        idle(6);
        // R3 R8: valid held through bursts, new words waiting while busy
        for (int i = 0; i < 20; i++) send(rnd_data(), $urandom(), 1'b1);
        in_valid = 1'b0;
        idle(6);
        for (int i = 0; i < 20; i++) begin
            send(rnd_data(), $urandom(), 1'b0);
            idle(i % 3);
        end
        idle(6);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule